// File: doc/BRIEF.md
# Multi-Port Synchronous FIFO Queue

This block is a single-clock queue with several parallel write lanes and several parallel read lanes. In any cycle a producer may push any subset of its write lanes, and a consumer may pop a prefix of its read lanes. Words keep one global order across lanes and across cycles. Lower lanes come first within a cycle, and earlier cycles come before later ones.

The ports follow stream rules. On the write side, `full` is the shared inverse of ready for every write lane. A lane's word is taken at a rising edge only when its `wr_en` bit is high and `full` is low. On the read side, each lane carries its own inverse valid, `rd_empty[i]`. The matching `rd_take[i]` bit is that lane's ready. Read lane i always shows the i-th oldest stored word, so the consumer takes a contiguous run starting at lane 0. `afull` and `aempty` give early warning to the flow control on either side.

The requested depth is rounded up to the next power of two. This lets the pointers wrap without any comparison logic.

Top module: `mpq_fifo`

## Requirements
- R1: In one cycle, 0 to WP words may be written and 0 to RP words popped at the same time. The occupancy changes by the number of writes minus the number of pops, and words leave in the order they were accepted.
- R2: Among the write lanes enabled in one cycle, lane 0 is queued first and the highest lane last. Disabled lanes leave no gap in the queue.
- R3: `full` is high when free space (depth minus occupancy) is less than WP. While `full` is high, every `wr_en` bit is ignored for that cycle.
- R4: Read lane i presents the i-th oldest stored word. `rd_take` must be a run of ones from bit 0, and a high `rd_take[i]` pops that lane's word.
- R5: `rd_empty[i]` is high exactly when the occupancy is at most i.
- R6: With SAFE_RD=1, a `rd_take` bit on a lane whose `rd_empty` is high removes nothing. The occupancy falls only by the number of valid lanes taken.
- R7: `afull` is high when the occupancy is at least depth minus AF_OFS.
- R8: `aempty` is high when the occupancy is at most AE_OFS.
- R9: The depth is DEPTH_REQ rounded up to a power of two. With the default DEPTH_REQ=12 the queue holds 16 words.
- R10: The reset is synchronous and active high. It empties the queue, so all `rd_empty` bits and `aempty` are high, and `full` and `afull` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_data | input | WP*DW | Write words, lane i at bits [i*DW +: DW] |
| wr_en | input | WP | Per-lane write enable |
| full | output | 1 | Space below WP words; writes ignored |
| afull | output | 1 | Almost-full flag |
| rd_data | output | RP*DW | Read words, lane i at bits [i*DW +: DW] |
| rd_take | input | RP | Per-lane pop, contiguous from bit 0 |
| rd_empty | output | RP | Per-lane not-valid flag |
| aempty | output | 1 | Almost-empty flag |

## Verification
The hardest state to reach from the ports is the one where the queue sits exactly at the `full` threshold and pointers have wrapped, while a write is refused. The stimulus fills the queue four words per cycle until `full` rises and then offers a further full-width write. The queue is then drained two lanes per cycle, so a refused word that slipped in would show up in the read order. A separate scenario pops both lanes while only one word is held and then writes one word. This shows that the over-request neither underflowed the queue nor skipped a word.

// File: rtl/mpq_pkg.sv
package mpq_pkg;
  function automatic int unsigned pow2_ceil(input int unsigned n);
    int unsigned p;
    p = 1;
    while (p < n) p = p * 2;
    return p;
  endfunction
endpackage

// File: rtl/mpq_wr_lanes.sv
module mpq_wr_lanes #(
  parameter int WP = 4,
  parameter int AW = 4,
  parameter int CW = 5
) (
  input  logic [WP-1:0]         wr_en,
  input  logic                  accept,
  input  logic [AW-1:0]         wptr,
  output logic [WP-1:0][AW-1:0] waddr,
  output logic [WP-1:0]         we,
  output logic [CW-1:0]         n_wr
);
  logic [CW-1:0] acc;

  // each enabled lane lands after the enabled lanes below it
  always_comb begin
    acc = '0;
    for (int i = 0; i < WP; i++) begin
      waddr[i] = wptr + acc[AW-1:0];
      we[i]    = accept & wr_en[i];
      if (wr_en[i]) acc = acc + CW'(1);
    end
    n_wr = accept ? acc : '0;
  end
endmodule

// File: rtl/mpq_rd_lanes.sv
module mpq_rd_lanes #(
  parameter int RP      = 2,
  parameter int AW      = 4,
  parameter int CW      = 5,
  parameter bit SAFE_RD = 1'b1
) (
  input  logic [RP-1:0]         rd_take,
  input  logic [CW-1:0]         occ,
  input  logic [AW-1:0]         rptr,
  output logic [RP-1:0][AW-1:0] raddr,
  output logic [RP-1:0]         empty,
  output logic [CW-1:0]         n_rd
);
  logic [CW-1:0] req;

  for (genvar j = 0; j < RP; j++) begin : g_lane
    assign raddr[j] = rptr + AW'(j);
    assign empty[j] = (occ <= CW'(j));
  end

  always_comb begin
    req = '0;
    for (int j = 0; j < RP; j++)
      if (rd_take[j]) req = req + CW'(1);
  end

  if (SAFE_RD) begin : g_safe
    assign n_rd = (req > occ) ? occ : req;
  end else begin : g_fast
    assign n_rd = req;
  end
endmodule

// File: rtl/mpq_level.sv
module mpq_level #(
  parameter int DEPTH  = 16,
  parameter int WP     = 4,
  parameter int AF_OFS = 2,
  parameter int AE_OFS = 1,
  parameter int CW     = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] n_wr,
  input  logic [CW-1:0] n_rd,
  output logic [CW-1:0] occ,
  output logic          full,
  output logic          afull,
  output logic          aempty
);
  logic [CW-1:0] free_sp;

  always_ff @(posedge clk) begin
    if (rst) occ <= '0;
    else     occ <= occ + n_wr - n_rd;
  end

  assign free_sp = CW'(DEPTH) - occ;
  assign full    = free_sp < CW'(WP);
  assign afull   = occ >= CW'(DEPTH - AF_OFS);
  assign aempty  = occ <= CW'(AE_OFS);
endmodule

// File: rtl/mpq_fifo.sv
module mpq_fifo #(
  parameter int DW        = 8,
  parameter int DEPTH_REQ = 12,
  parameter int WP        = 4,
  parameter int RP        = 2,
  parameter int AF_OFS    = 2,
  parameter int AE_OFS    = 1,
  parameter bit SAFE_RD   = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WP*DW-1:0] wr_data,
  input  logic [WP-1:0]    wr_en,
  output logic             full,
  output logic             afull,
  output logic [RP*DW-1:0] rd_data,
  input  logic [RP-1:0]    rd_take,
  output logic [RP-1:0]    rd_empty,
  output logic             aempty
);
  localparam int DEPTH = mpq_pkg::pow2_ceil(DEPTH_REQ);
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW    = AW + 1;

  logic [DW-1:0]         mem [DEPTH];
  logic [AW-1:0]         wptr, rptr;
  logic [CW-1:0]         level, n_wr, n_rd;
  logic [WP-1:0][AW-1:0] waddr;
  logic [WP-1:0]         we;
  logic [RP-1:0][AW-1:0] raddr;

  mpq_wr_lanes #(.WP(WP), .AW(AW), .CW(CW)) u_wr (
    .wr_en(wr_en), .accept(~full), .wptr(wptr),
    .waddr(waddr), .we(we), .n_wr(n_wr)
  );

  mpq_rd_lanes #(.RP(RP), .AW(AW), .CW(CW), .SAFE_RD(SAFE_RD)) u_rd (
    .rd_take(rd_take), .occ(level), .rptr(rptr),
    .raddr(raddr), .empty(rd_empty), .n_rd(n_rd)
  );

  mpq_level #(.DEPTH(DEPTH), .WP(WP), .AF_OFS(AF_OFS), .AE_OFS(AE_OFS), .CW(CW)) u_lvl (
    .clk(clk), .rst(rst), .n_wr(n_wr), .n_rd(n_rd),
    .occ(level), .full(full), .afull(afull), .aempty(aempty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      wptr <= wptr + n_wr[AW-1:0];
      rptr <= rptr + n_rd[AW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < WP; i++)
      if (we[i]) mem[waddr[i]] <= wr_data[i*DW +: DW];
  end

  always_comb begin
    for (int j = 0; j < RP; j++)
      rd_data[j*DW +: DW] = mem[raddr[j]];
  end
endmodule

// File: rtl/mpq_fifo_chk.sv
module mpq_fifo_chk #(
  parameter int WP      = 4,
  parameter int RP      = 2,
  parameter int DEPTH   = 16,
  parameter int CW      = 5,
  parameter bit SAFE_RD = 1'b1
) (
  input logic          clk,
  input logic          rst,
  input logic [WP-1:0] wr_en,
  input logic [RP-1:0] rd_take,
  input logic [RP-1:0] rd_empty,
  input logic          full,
  input logic          afull,
  input logic          aempty,
  input logic [CW-1:0] occ
);
  logic [RP-1:0] valid_v;
  assign valid_v = ~rd_empty;

  p_occ_bound_r1: assert property (@(posedge clk) disable iff (rst)
    int'(occ) <= DEPTH);

  p_step_size_r1: assert property (@(posedge clk) disable iff (rst)
    (int'(occ) <= int'($past(occ)) + WP) && (int'(occ) + RP >= int'($past(occ))));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (full && rd_take == '0) |=> occ == $past(occ));

  p_valid_prefix_r5: assert property (@(posedge clk) disable iff (rst)
    (valid_v & (valid_v + RP'(1))) == '0);

  if (SAFE_RD) begin : g_safe
    p_empty_take_r6: assert property (@(posedge clk) disable iff (rst)
      (rd_empty[0] && wr_en == '0) |=> rd_empty[0]);
  end

  p_reset_state_r10: assert property (@(posedge clk)
    rst |=> (&rd_empty) && aempty && !full && !afull);
endmodule

bind mpq_fifo mpq_fifo_chk #(
  .WP(WP), .RP(RP), .DEPTH(DEPTH), .CW(CW), .SAFE_RD(SAFE_RD)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_take(rd_take),
  .rd_empty(rd_empty), .full(full), .afull(afull), .aempty(aempty),
  .occ(level)
);

// File: tb/test_mpq_fifo.sv
module test_mpq_fifo;
  localparam int DW = 8, WP = 4, RP = 2;
  localparam int DEPTH_E = 16;  // R9: 12 requested -> 16
  localparam int AF = 2, AE = 1;

  logic clk = 1'b0, rst = 1'b1;
  logic [WP*DW-1:0] wr_data = '0;
  logic [WP-1:0]    wr_en = '0;
  logic [RP-1:0]    rd_take = '0;
  logic             full, afull, aempty;
  logic [RP*DW-1:0] rd_data;
  logic [RP-1:0]    rd_empty;

  int total = 0, bad = 0;
  bit done = 0;
  logic [DW-1:0] q[$];
  logic [DW-1:0] seq = 8'h10;

  always #4 clk = ~clk;

  mpq_fifo #(.DW(DW), .DEPTH_REQ(12), .WP(WP), .RP(RP),
             .AF_OFS(AF), .AE_OFS(AE), .SAFE_RD(1'b1)) i_mpq_fifo (
    .clk(clk), .rst(rst), .wr_data(wr_data), .wr_en(wr_en), .full(full),
    .afull(afull), .rd_data(rd_data), .rd_take(rd_take),
    .rd_empty(rd_empty), .aempty(aempty)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int j = 0; j < RP; j++) begin
      chk(tag, $sformatf("empty[%0d]", j), int'(rd_empty[j]), int'(q.size() <= j));
      if (q.size() > j)
        chk(tag, $sformatf("data[%0d]", j), int'(rd_data[j*DW +: DW]), int'(q[j]));
    end
    chk(tag, "full",   int'(full),   int'((DEPTH_E - q.size()) < WP));
    chk(tag, "afull",  int'(afull),  int'(q.size() >= DEPTH_E - AF));
    chk(tag, "aempty", int'(aempty), int'(q.size() <= AE));
  endtask

  // one clock: drive, update model at the edge, release inputs after it
  task automatic step(input logic [WP-1:0] w, input logic [RP-1:0] r);
    int pre, npop;
    @(negedge clk);
    for (int i = 0; i < WP; i++) begin
      wr_data[i*DW +: DW] = seq;
      seq = seq + 8'd1;
    end
    wr_en = w;
    rd_take = r;
    @(posedge clk);
    pre = q.size();
    npop = $countones(r);
    if (npop > pre) npop = pre;
    for (int k = 0; k < npop; k++) void'(q.pop_front());
    if (DEPTH_E - pre >= WP)
      for (int i = 0; i < WP; i++)
        if (w[i]) q.push_back(wr_data[i*DW +: DW]);
    #1;
    wr_en = '0;
    rd_take = '0;
  endtask

  task automatic drain(input string tag);
    while (q.size() > 0) begin
      step('0, 2'b11);
      check_all(tag);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    q.delete();
    check_all("R10");
  endtask

  task automatic t_basic;
    step(4'b0001, 2'b00); check_all("R1");
    step(4'b0001, 2'b00); check_all("R4");
    step(4'b0000, 2'b01); check_all("R4");
    step(4'b0011, 2'b01); check_all("R1");
    drain("R4");
  endtask

  task automatic t_lane_order;
    step(4'b1010, 2'b00); check_all("R2");
    step(4'b0101, 2'b00); check_all("R2");
    step(4'b1111, 2'b00); check_all("R2");
    drain("R2");
  endtask

  task automatic t_fill;
    for (int c = 0; c < 4; c++) begin
      step(4'b1111, 2'b00);
      check_all("R9");
    end
    chk("R3", "full at 16", int'(full), 1);
    chk("R7", "afull at 16", int'(afull), 1);
    step(4'b1111, 2'b00); check_all("R3");
    step(4'b1111, 2'b01); check_all("R3");  // 15 held, still full
    drain("R3");
  endtask

  task automatic t_thresholds;
    step(4'b0001, 2'b00); check_all("R8");
    step(4'b0001, 2'b00); check_all("R8");
    step(4'b1111, 2'b00); check_all("R7");
    step(4'b1111, 2'b00); check_all("R7");
    step(4'b1111, 2'b00); check_all("R7");  // 14
    step(4'b0000, 2'b01); check_all("R7");  // 13
    step(4'b0000, 2'b01); check_all("R5");
    drain("R5");
  endtask

  task automatic t_simul;
    step(4'b0111, 2'b00); check_all("R1");
    step(4'b0111, 2'b11); check_all("R1");
    step(4'b1001, 2'b11); check_all("R1");
    drain("R1");
  endtask

  task automatic t_safe;
    step(4'b0000, 2'b11); check_all("R6");
    step(4'b0001, 2'b00); check_all("R6");
    step(4'b0000, 2'b11); check_all("R6");
    step(4'b0100, 2'b00); check_all("R6");
    chk("R6", "one word held", int'(rd_empty), 2'b10);
    drain("R6");
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_up();
  end

  initial begin
    t_reset();
    t_basic();
    t_lane_order();
    t_fill();
    t_thresholds();
    t_simul();
    t_safe();
    step(4'b1111, 2'b00);
    t_reset();
    finish_up();
  end
endmodule